// File: doc/BRIEF.md
# ADC Channel-List Scan Sequencer

This block is the digital front end of a 16-channel, 12-bit analog-to-digital converter. Host software reaches it through a small 16-bit register bus. It loads a list of 8-bit channel entries and picks how conversions are triggered: by a bus read, by a periodic scan tick from a timer, or by an edge on an external trigger pin. On each trigger the sequencer steps through the list. For every entry it drives the channel, gain, polarity and input-type selects to the converter, pulses a start strobe, waits for the converter's done strobe and stores the sample in a result FIFO. The host polls a status word, reads results and acknowledges the FIFO half-full interrupt.

The sequencer is a three-state machine. IDLE waits for a trigger. ISSUE drives the start strobe for one cycle. WAIT holds the selects until the converter answers. The transitions are:
- LAUNCH (IDLE to ISSUE): a trigger arrives while the list holds entries. The list index restarts at 0.
- ISSUED (ISSUE to WAIT): unconditional, after one cycle.
- ADVANCE (WAIT to ISSUE): the sample is done and either more entries remain or continuous mode wraps the index to 0.
- FINISH (WAIT to IDLE): the last entry is done and continuous mode is off.
- ABORT (any state to IDLE): the mode is set to off or the list is emptied. Abort takes priority over every other transition.

Emptying the list or the result FIFO is done by clearing its enable bit in the second control register.

Register map (byte offsets; address bit 0 is ignored):

| Offset | Write | Read |
|---|---|---|
| 0x00 | control word A | start a conversion |
| 0x02 | control word B | — |
| 0x04 | clear the interrupt | status word |
| 0x10 | channel-list entry | result |

Top module: `adc_scan_frontend`

## Requirements
- R1: A list entry written at byte offset 0x10 (write data bits 7:0) is decoded as follows: bits 3:0 are the channel, bits 5:4 the gain code, bit 6 unipolar and bit 7 differential. While that entry converts, these fields appear on conv_chan, conv_gain, conv_unipolar and conv_diff.
- R2: Control word A (write, offset 0x00) bits 1:0 choose the trigger source. The encodings are 0 off, 1 a bus read of offset 0x00, 2 a scan_tick pulse, and 3 an edge on ext_trig. Bit 3 set selects the falling edge; bit 3 clear selects the rising edge. A trigger from a source that is not selected starts nothing. Mode 0 stops the sequencer.
- R3: With continuous mode off (control word A bit 2 clear), one trigger converts each list entry once, in the order the entries were written, and the sequencer then returns to idle. Each conversion gives one conv_start pulse lasting one cycle.
- R4: With control word A bit 2 set, the sequencer wraps from the last entry back to the first and keeps converting until the mode is set to 0.
- R5: The status word (read, offset 0x04) has these bits: bit 0 sequencer busy, bit 1 list full, bit 2 result FIFO empty, bit 3 result FIFO half full (at least RES_DEPTH/2 words), bit 4 result FIFO full, bit 8 half-full interrupt pending. All other bits read 0.
- R6: Control word B (write, offset 0x02) bit 10 enables the result FIFO and bit 9 enables the list. While either bit is clear, the matching store is held empty and writes or pushes into it are discarded.
- R7: Reading offset 0x10 pops the oldest result. The result is returned in bits 11:0 as the converter sample with bit 11 inverted (offset binary), and bits 15:12 are 0. A read of 0x10 from an empty FIFO returns 0.
- R8: A sample that arrives while the result FIFO is full is discarded. The full flag stays set until a result is read.
- R9: When control word A bit 8 is set and the FIFO count rises to half full, the pending flag is set. The irq output is high when the pending flag is set and control word A bit 15 is set. Any write to offset 0x04 clears the pending flag.
- R10: The list holds LIST_DEPTH entries. A write to a full list is discarded.
- R11: A trigger that arrives while the sequencer is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of 0x10 pops the result FIFO and a read of 0x00 can trigger |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the same cycle as bus_rd |
| scan_tick | input | 1 | Scan timer pulse (mode 2) |
| ext_trig | input | 1 | External trigger level (mode 3) |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| conv_chan | output | 4 | Selected input channel |
| conv_gain | output | 2 | Selected gain code |
| conv_unipolar | output | 1 | Unipolar range select |
| conv_diff | output | 1 | Differential input select |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 12 | Converter sample (two's complement), valid with conv_done |
| irq | output | 1 | Half-full interrupt request |

## Verification
The bench runs a three-entry list in continuous mode until the FIFO fills, then stops the sequencer. A design that overwrote old results, or let the full flag drop on its own, would return samples out of the wrapped 5-9-2 order or report a non-full status. The bench loads one more entry than the list can hold and counts conversions: a list that accepted the extra write would convert seventeen times. It fires every trigger source while a different mode is selected, and both edges of ext_trig under each polarity setting; a wrong mode decode shows up as an extra or missing conversion. It also flushes both stores while they hold data, and checks that a half-full event raises a pending flag that stays off the irq pin while the global enable is clear. A design that kept stale entries or gated the flag itself would fail these checks.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int BUS_W    = 16;
    localparam int SAMPLE_W = 12;

    // Byte offsets of the register window
    localparam int OFS_CTRL_A = 'h00;   // write: control A, read: start
    localparam int OFS_CTRL_B = 'h02;   // write: control B
    localparam int OFS_STAT   = 'h04;   // read: status, write: clear interrupt
    localparam int OFS_DATA   = 'h10;   // write: list entry, read: result

    // Control word A bits
    localparam int CA_CONT    = 2;
    localparam int CA_FALL    = 3;
    localparam int CA_HF_IE   = 8;
    localparam int CA_GLB_IE  = 15;

    // Control word B bits
    localparam int CB_LIST_EN = 9;
    localparam int CB_FIFO_EN = 10;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_SOFT = 2'd1,
        MODE_SCAN = 2'd2,
        MODE_EXT  = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       diff;
        logic       unipolar;
        logic [1:0] gain;
        logic [3:0] chan;
    } list_entry_t;

endpackage

// File: rtl/adcseq_chan_list.sv
module adcseq_chan_list
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  list_entry_t       wr_entry,
    input  logic [IDX_W-1:0]  rd_idx,
    output list_entry_t       rd_entry,
    output logic [CNT_W-1:0]  count,
    output logic              full
);

    list_entry_t mem [DEPTH];

    assign full     = (count == CNT_W'(DEPTH));
    assign rd_entry = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!enable) begin
            count <= '0;
        end else if (wr_en && !full) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (enable && wr_en && !full) begin
            mem[count[IDX_W-1:0]] <= wr_entry;
        end
    end

    // A write into a full list leaves the entry count untouched (R10)
    p_list_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && full && wr_en) |=> (count == $past(count)));

    // A disabled list is empty on the next cycle (R6)
    p_list_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (count == '0));

endmodule

// File: rtl/adcseq_result_fifo.sv
module adcseq_result_fifo
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = SAMPLE_W,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              push,
    input  logic [WIDTH-1:0]  push_data,
    input  logic              pop,
    output logic [WIDTH-1:0]  head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              half,
    output logic              full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             pop_ok, push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign half    = (count >= CNT_W'(DEPTH / 2));
    assign head    = mem[rd_ptr];
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (!enable) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (enable && push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Once full, the FIFO stays full until a word is popped (R8)
    p_full_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && full && !pop) |=> full);

    // A disabled FIFO reads back empty on the next cycle (R6)
    p_fifo_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> empty);

endmodule

// File: rtl/adcseq_seq_fsm.sv
module adcseq_seq_fsm
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trig_mode_e        mode,
    input  logic              continuous,
    input  logic              trigger,
    input  logic [CNT_W-1:0]  list_count,
    input  logic              conv_done,
    output logic [IDX_W-1:0]  idx,
    output logic              conv_start,
    output logic              busy,
    output logic              push
);

    seq_state_e state, state_nx;
    logic       abort, last, launch, advance;

    assign abort   = (mode == MODE_OFF) || (list_count == '0);
    assign last    = ((CNT_W'(idx) + 1'b1) == list_count);
    assign launch  = (state == SEQ_IDLE) && trigger && !abort;
    assign advance = (state == SEQ_WAIT) && conv_done && !abort;

    // Next-state decode
    always_comb begin
        state_nx = state;
        if (abort) begin
            state_nx = SEQ_IDLE;                        // ABORT
        end else begin
            unique case (state)
                SEQ_IDLE:  if (trigger) state_nx = SEQ_ISSUE;   // LAUNCH
                SEQ_ISSUE: state_nx = SEQ_WAIT;                 // ISSUED
                SEQ_WAIT:  if (conv_done) begin
                               if (last && !continuous)
                                   state_nx = SEQ_IDLE;         // FINISH
                               else
                                   state_nx = SEQ_ISSUE;        // ADVANCE
                           end
                default:   state_nx = SEQ_IDLE;
            endcase
        end
    end

    // State and list index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (launch)       idx <= '0;
            else if (advance) idx <= last ? '0 : idx + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        conv_start = 1'b0;
        push       = 1'b0;
        busy       = 1'b1;
        unique case (state)
            SEQ_IDLE:  busy       = 1'b0;
            SEQ_ISSUE: conv_start = 1'b1;
            SEQ_WAIT:  push       = conv_done && !abort;
            default:   busy       = 1'b0;
        endcase
    end

    // The start strobe lasts exactly one cycle (R3)
    p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // Mode off returns the sequencer to idle on the next cycle (R2)
    p_abort_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !busy);

    // A trigger while busy does not restart the list (R11)
    p_busy_ignores_trigger_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WAIT && !conv_done && !abort && trigger) |=> (state == SEQ_WAIT));

endmodule

// File: rtl/adc_scan_frontend.sv
module adc_scan_frontend
    import adcseq_pkg::*;
#(
    parameter int LIST_DEPTH = 16,
    parameter int RES_DEPTH  = 16,
    parameter int ADDR_W     = 5,
    localparam int LIDX_W = $clog2(LIST_DEPTH),
    localparam int LCNT_W = $clog2(LIST_DEPTH + 1),
    localparam int RCNT_W = $clog2(RES_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic                 scan_tick,
    input  logic                 ext_trig,
    output logic                 conv_start,
    output logic [3:0]           conv_chan,
    output logic [1:0]           conv_gain,
    output logic                 conv_unipolar,
    output logic                 conv_diff,
    input  logic                 conv_done,
    input  logic [SAMPLE_W-1:0]  conv_data,
    output logic                 irq
);

    logic [BUS_W-1:0]    ctrl_a, ctrl_b;
    logic [ADDR_W-1:0]   word_addr;
    logic                hit_a, hit_stat, hit_data;
    trig_mode_e          mode;
    logic                ext_q, ext_edge, trigger;
    logic                list_full, busy, seq_push;
    logic [LCNT_W-1:0]   list_count;
    logic [LIDX_W-1:0]   list_idx;
    list_entry_t         cur_entry;
    logic [SAMPLE_W-1:0] fifo_head;
    logic [RCNT_W-1:0]   fifo_count;
    logic                fifo_empty, fifo_half, fifo_full, fifo_pop;
    logic                half_q, half_rise, irq_pend, clr_wr;

    assign word_addr = {bus_addr[ADDR_W-1:1], 1'b0};
    assign hit_a     = (word_addr == ADDR_W'(OFS_CTRL_A));
    assign hit_stat  = (word_addr == ADDR_W'(OFS_STAT));
    assign hit_data  = (word_addr == ADDR_W'(OFS_DATA));
    assign mode      = trig_mode_e'(ctrl_a[1:0]);
    assign clr_wr    = bus_wr && hit_stat;
    assign fifo_pop  = bus_rd && hit_data;

    // Control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
        end else if (bus_wr) begin
            if (hit_a)                                   ctrl_a <= bus_wdata;
            if (word_addr == ADDR_W'(OFS_CTRL_B))        ctrl_b <= bus_wdata;
        end
    end

    // Trigger source selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_trig;
    end

    assign ext_edge = ctrl_a[CA_FALL] ? (ext_q && !ext_trig) : (!ext_q && ext_trig);

    always_comb begin
        unique case (mode)
            MODE_OFF:  trigger = 1'b0;
            MODE_SOFT: trigger = bus_rd && hit_a;
            MODE_SCAN: trigger = scan_tick;
            MODE_EXT:  trigger = ext_edge;
            default:   trigger = 1'b0;
        endcase
    end

    adcseq_chan_list #(.DEPTH(LIST_DEPTH)) u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctrl_b[CB_LIST_EN]),
        .wr_en    (bus_wr && hit_data),
        .wr_entry (list_entry_t'(bus_wdata[7:0])),
        .rd_idx   (list_idx),
        .rd_entry (cur_entry),
        .count    (list_count),
        .full     (list_full)
    );

    adcseq_seq_fsm #(.DEPTH(LIST_DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .continuous (ctrl_a[CA_CONT]),
        .trigger    (trigger),
        .list_count (list_count),
        .conv_done  (conv_done),
        .idx        (list_idx),
        .conv_start (conv_start),
        .busy       (busy),
        .push       (seq_push)
    );

    assign conv_chan     = cur_entry.chan;
    assign conv_gain     = cur_entry.gain;
    assign conv_unipolar = cur_entry.unipolar;
    assign conv_diff     = cur_entry.diff;

    adcseq_result_fifo #(.DEPTH(RES_DEPTH), .WIDTH(SAMPLE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctrl_b[CB_FIFO_EN]),
        .push      (seq_push),
        .push_data (conv_data ^ SAMPLE_W'(1 << (SAMPLE_W - 1))),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .half      (fifo_half),
        .full      (fifo_full)
    );

    // Half-full interrupt
    assign half_rise = fifo_half && !half_q && ctrl_a[CA_HF_IE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q   <= 1'b0;
            irq_pend <= 1'b0;
        end else begin
            half_q <= fifo_half;
            if (half_rise)   irq_pend <= 1'b1;
            else if (clr_wr) irq_pend <= 1'b0;
        end
    end

    assign irq = irq_pend && ctrl_a[CA_GLB_IE];

    // Read data
    always_comb begin
        bus_rdata = '0;
        if (hit_stat) begin
            bus_rdata[0] = busy;
            bus_rdata[1] = list_full;
            bus_rdata[2] = fifo_empty;
            bus_rdata[3] = fifo_half;
            bus_rdata[4] = fifo_full;
            bus_rdata[8] = irq_pend;
        end else if (hit_data && !fifo_empty) begin
            bus_rdata[SAMPLE_W-1:0] = fifo_head;
        end
    end

    // A clear write with no new half-full event drops the pending flag (R9)
    p_clear_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !half_rise) |=> !irq_pend);

    // The FIFO never reports more words than it can hold (R8)
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= RCNT_W'(RES_DEPTH));

endmodule

// File: tb/adc_scan_frontend_test.sv
module adc_scan_frontend_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        scan_tick = 1'b0, ext_trig = 1'b0;
    logic        conv_start, conv_unipolar, conv_diff, irq;
    logic [3:0]  conv_chan;
    logic [1:0]  conv_gain;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;

    int checks = 0, errors = 0;
    int conv_n = 0;
    int lg_chan [64];
    int lg_gain [64];
    int lg_uni  [64];
    int lg_diff [64];
    int lat = 0;
    logic [3:0] held_chan = '0;

    always #(CLK_P/2) clk = ~clk;

    adc_scan_frontend uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .scan_tick(scan_tick), .ext_trig(ext_trig), .conv_start(conv_start),
        .conv_chan(conv_chan), .conv_gain(conv_gain), .conv_unipolar(conv_unipolar),
        .conv_diff(conv_diff), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
    );

    function automatic logic [11:0] samp(input logic [3:0] c);
        return {c, ~c, 4'h6};
    endfunction

    function automatic int expect_rd(input int c);
        return int'(samp(4'(c)) ^ 12'h800);
    endfunction

    // Converter model: answers a start strobe after a short latency
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            if (conv_n < 64) begin
                lg_chan[conv_n] <= int'(conv_chan);
                lg_gain[conv_n] <= int'(conv_gain);
                lg_uni[conv_n]  <= int'(conv_unipolar);
                lg_diff[conv_n] <= int'(conv_diff);
            end
            conv_n    <= conv_n + 1;
            held_chan <= conv_chan;
            lat       <= 3;
        end else if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                conv_done <= 1'b1;
                conv_data <= samp(held_chan);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_addr = 5'(a); bus_wdata = 16'(d); bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 5'(a); bus_rd = 1'b1;
        #1 d = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic flush_all();
        wr('h02, 'h0000);
        wr('h02, 'h0600);
    endtask

    task automatic soft_trig();
        int d;
        rd('h00, d);
    endtask

    task automatic t_reset();
        int d;
        rd('h04, d);
        chk_eq("R5 reset status", d, 'h0004);
        chk_eq("R9 reset irq", int'(irq), 0);
        chk_eq("R3 reset start", int'(conv_start), 0);
    endtask

    task automatic t_mode_off();
        int n0;
        flush_all();
        wr('h10, 'h03);
        wr('h00, 'h0000);
        n0 = conv_n;
        soft_trig();
        scan_tick = 1'b1; @(negedge clk); scan_tick = 1'b0;
        ext_trig = 1'b1; idle(2); ext_trig = 1'b0;
        idle(20);
        chk_eq("R2 mode off no conversion", conv_n - n0, 0);
    endtask

    task automatic t_soft_single();
        int d, n0;
        flush_all();
        wr('h10, 'hA7);
        wr('h00, 'h0001);
        n0 = conv_n;
        soft_trig();
        idle(1);
        rd('h04, d);
        chk_eq("R5 busy bit while converting", d & 1, 1);
        idle(20);
        chk_eq("R3 single conversion count", conv_n - n0, 1);
        chk_eq("R1 chan", lg_chan[n0], 7);
        chk_eq("R1 gain", lg_gain[n0], 2);
        chk_eq("R1 unipolar", lg_uni[n0], 0);
        chk_eq("R1 diff", lg_diff[n0], 1);
        rd('h04, d);
        chk_eq("R3 idle after list, one result", d, 'h0000);
        rd('h10, d);
        chk_eq("R7 result offset binary", d, expect_rd(7));
        rd('h10, d);
        chk_eq("R7 empty read returns 0", d, 0);
        rd('h04, d);
        chk_eq("R5 empty after read", d, 'h0004);
    endtask

    task automatic t_multi();
        int d, n0;
        int chans [3] = '{3, 12, 15};
        flush_all();
        wr('h10, 'h03); wr('h10, 'h5C); wr('h10, 'h4F);
        wr('h00, 'h0001);
        n0 = conv_n;
        soft_trig();
        soft_trig();   // arrives while busy: ignored (R11)
        idle(40);
        chk_eq("R11 trigger while busy ignored", conv_n - n0, 3);
        for (int i = 0; i < 3; i++)
            chk_eq("R3 list order", lg_chan[n0 + i], chans[i]);
        chk_eq("R1 gain entry 0x5C", lg_gain[n0 + 1], 1);
        chk_eq("R1 unipolar entry 0x5C", lg_uni[n0 + 1], 1);
        chk_eq("R1 diff entry 0x5C", lg_diff[n0 + 1], 0);
        for (int i = 0; i < 3; i++) begin
            rd('h10, d);
            chk_eq("R7 result order", d, expect_rd(chans[i]));
        end
    endtask

    task automatic t_scan_ext();
        int n0;
        flush_all();
        wr('h10, 'h01);
        wr('h00, 'h0002);
        n0 = conv_n;
        soft_trig();
        idle(15);
        chk_eq("R2 bus read ignored in scan mode", conv_n - n0, 0);
        scan_tick = 1'b1; @(negedge clk); scan_tick = 1'b0;
        idle(15);
        chk_eq("R2 scan tick triggers", conv_n - n0, 1);
        wr('h00, 'h0003);
        n0 = conv_n;
        scan_tick = 1'b1; @(negedge clk); scan_tick = 1'b0;
        idle(15);
        chk_eq("R2 scan tick ignored in ext mode", conv_n - n0, 0);
        ext_trig = 1'b1; idle(15);
        chk_eq("R2 rising edge triggers", conv_n - n0, 1);
        ext_trig = 1'b0; idle(15);
        chk_eq("R2 falling edge ignored when rising chosen", conv_n - n0, 1);
        wr('h00, 'h000B);
        ext_trig = 1'b1; idle(15);
        chk_eq("R2 rising edge ignored when falling chosen", conv_n - n0, 1);
        ext_trig = 1'b0; idle(15);
        chk_eq("R2 falling edge triggers", conv_n - n0, 2);
    endtask

    task automatic t_flush();
        int d, n0;
        wr('h00, 'h0001);
        rd('h04, d);
        chk_eq("R6 results present before flush", d & 'h4, 0);
        wr('h02, 'h0000);
        wr('h10, 'h05);
        wr('h02, 'h0600);
        rd('h04, d);
        chk_eq("R6 status after flush", d, 'h0004);
        n0 = conv_n;
        soft_trig();
        idle(20);
        chk_eq("R6 list write while disabled dropped", conv_n - n0, 0);
    endtask

    task automatic t_list_full();
        int d, n0;
        flush_all();
        for (int i = 0; i < 16; i++) wr('h10, i);
        rd('h04, d);
        chk_eq("R10 list full flag", d & 'h2, 'h2);
        wr('h10, 'hFF);
        wr('h00, 'h0001);
        n0 = conv_n;
        soft_trig();
        idle(200);
        chk_eq("R10 extra entry dropped", conv_n - n0, 16);
        rd('h04, d);
        chk_eq("R5 full and half", d, 'h001A);
        for (int i = 0; i < 16; i++) begin
            rd('h10, d);
            chk_eq("R10 result sequence", d, expect_rd(i));
        end
    endtask

    task automatic t_continuous();
        int d;
        int chans [3] = '{5, 9, 2};
        flush_all();
        wr('h10, 'h05); wr('h10, 'h09); wr('h10, 'h02);
        wr('h00, 'h0005);
        soft_trig();
        idle(200);
        rd('h04, d);
        chk_eq("R4 still busy, FIFO full", d & 'h11, 'h11);
        wr('h00, 'h0000);
        idle(20);
        rd('h04, d);
        chk_eq("R8 full held after stop", d, 'h0018);
        for (int i = 0; i < 16; i++) begin
            rd('h10, d);
            chk_eq("R4 wrapped order, R8 oldest kept", d, expect_rd(chans[i % 3]));
        end
        rd('h04, d);
        chk_eq("R8 drained", d, 'h0004);
    endtask

    task automatic t_irq();
        int d;
        flush_all();
        for (int i = 0; i < 8; i++) wr('h10, i);
        wr('h00, 'h8101);
        soft_trig();
        idle(120);
        chk_eq("R9 irq raised at half full", int'(irq), 1);
        rd('h04, d);
        chk_eq("R9 pending in status", d, 'h0108);
        wr('h04, 'h0000);
        chk_eq("R9 irq cleared", int'(irq), 0);
        rd('h04, d);
        chk_eq("R9 pending cleared, data kept", d, 'h0008);
        wr('h02, 'h0200);
        wr('h02, 'h0600);
        wr('h00, 'h0101);
        soft_trig();
        idle(120);
        rd('h04, d);
        chk_eq("R9 pending without global enable", d & 'h100, 'h100);
        chk_eq("R9 irq gated by global enable", int'(irq), 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_mode_off();
        t_soft_single();
        t_multi();
        t_scan_ext();
        t_flush();
        t_list_full();
        t_continuous();
        t_irq();
        idle(5);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule